// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block supports loads that a compiler has hoisted above stores that might alias them. When such an early load issues, it records its destination register, byte address and access size in a small fully associative table. Every store that follows is compared against all recorded byte ranges, and each entry it touches is dropped. When the program reaches the point where the load originally sat, a check names the destination register. A hit means no conflicting store came in between and the early value can be kept. A miss means recovery code must redo the load.

A speculative load that would have faulted does not trap. Instead it sets a deferred-fault flag for its destination register, and any entry that register held is removed. A clean speculative load to the same register clears the flag. Checks can be predicated. A check whose predicate is false produces no response and changes nothing. When the table is full, a new register takes the slot of the entry that was allocated longest ago. A free slot is always used before any entry is evicted.

Top module: `specLoadTracker`

## Requirements
- R1: After reset no entry is valid, every deferred-fault flag reads 0, and `chkDone` is 0.
- R2: A check with `chkValid` and `chkPred` high returns `chkDone`=1 on the cycle after it is presented. `chkHit` is 1 exactly when a valid entry tagged with `chkReg` existed before that cycle's updates.
- R3: A check on a register that has no entry reports `chkDone`=1 with `chkHit`=0.
- R4: Access size is encoded as 0,1,2,3 for 1,2,4,8 bytes. A store covering bytes [stAddr, stAddr+size) clears an entry exactly when that range intersects the entry's byte range. A store whose range does not intersect leaves the entry valid.
- R5: One store clears every overlapping entry in the same cycle. Entries it does not overlap survive.
- R6: When a store and a clean advanced load arrive in the same cycle, the invalidation is applied first. The new entry survives even if it overlaps the store.
- R7: A clean advanced load to a register that already has an entry replaces that entry's address and size. No two valid entries share a tag.
- R8: A new register goes into a free slot when one exists. With all 16 slots valid, it evicts the entry allocated longest ago, and a later check on the evicted register misses.
- R9: A check with `chkPred`=0 gives `chkDone`=0 on the next cycle and leaves the table unchanged.
- R10: An advanced load with `advFault`=1 sets the deferred-fault flag of `advReg`, allocates nothing, and removes any entry of that register. A clean advanced load clears the flag. `natQryBit` shows the flag of `natQryReg`.
- R11: A check sees the table as it stood before a store or advanced load presented in the same cycle.
- R12: A check that hits leaves its entry valid, so a repeated check hits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advValid | input | 1 | Advanced load present |
| advReg | input | 7 | Destination register of the advanced load |
| advAddr | input | 64 | Byte address of the advanced load |
| advSizeLog | input | 2 | Size code of the advanced load (0..3 for 1..8 bytes) |
| advFault | input | 1 | Advanced load would have faulted |
| stValid | input | 1 | Store present |
| stAddr | input | 64 | Byte address of the store |
| stSizeLog | input | 2 | Size code of the store |
| chkValid | input | 1 | Check present |
| chkPred | input | 1 | Qualifying predicate of the check |
| chkReg | input | 7 | Register named by the check |
| chkDone | output | 1 | Check response valid (one cycle after the check) |
| chkHit | output | 1 | Speculation confirmed |
| natQryReg | input | 7 | Register whose deferred-fault flag is read |
| natQryBit | output | 1 | Deferred-fault flag of `natQryReg` |

## Verification
The store-clearing property only applies to cycles with no advanced load, because a same-cycle allocation may legally land on an overlapping address. The property that tags are unique assumes the table is filled only through the advanced-load port. It therefore checks that a replacement never creates a second copy of a tag. The stimulus uses the four legal size codes, and it places each register's entry at a distinct, widely spaced address. This way, only the stores meant to collide with an entry do so. The overlap sweep walks store offsets from eight bytes below to eight bytes above an entry, crossing every size pair, so each edge of the range test is reached.

// File: rtl/sltPkg.sv
package sltPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic write;   // store tag/address/size into selected slot
    logic natSet;  // mark destination register as holding a deferred fault
    logic natClr;  // clear the deferred fault of the destination register
  } ctrlStrobes_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] sizeLog);
    return 4'(1) << sizeLog;
  endfunction
endpackage

// File: rtl/sltDatapath.sv
module sltDatapath
  import sltPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [ENTRIES-1:0]  wrSlot,
  input  logic [REG_W-1:0]    advReg,
  input  logic [ADDR_W-1:0]   advAddr,
  input  logic [1:0]          advSizeLog,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [1:0]          stSizeLog,
  input  logic [REG_W-1:0]    chkReg,
  input  logic [REG_W-1:0]    natQryReg,
  output logic [ENTRIES-1:0]  advTagHit,
  output logic [ENTRIES-1:0]  chkTagHit,
  output logic [ENTRIES-1:0]  stOverlap,
  output logic                natQryBit
);
  localparam int NUM_REGS = 1 << REG_W;
  localparam int WIDE_W   = ADDR_W + 1;

  logic [REG_W-1:0]  tagQ  [ENTRIES];
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [1:0]        sizeQ [ENTRIES];
  logic [NUM_REGS-1:0] natQ;

  logic [WIDE_W-1:0] stLo, stEnd;
  assign stLo  = {1'b0, stAddr};
  assign stEnd = stLo + {{(WIDE_W-4){1'b0}}, sizeBytes(stSizeLog)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]  <= '0;
        addrQ[i] <= '0;
        sizeQ[i] <= '0;
      end
    end else if (strb.write) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrSlot[i]) begin
          tagQ[i]  <= advReg;
          addrQ[i] <= advAddr;
          sizeQ[i] <= advSizeLog;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gCompare
    logic [WIDE_W-1:0] entLo, entEnd;
    assign entLo  = {1'b0, addrQ[g]};
    assign entEnd = entLo + {{(WIDE_W-4){1'b0}}, sizeBytes(sizeQ[g])};
    assign advTagHit[g] = (tagQ[g] == advReg);
    assign chkTagHit[g] = (tagQ[g] == chkReg);
    assign stOverlap[g] = (stLo < entEnd) && (entLo < stEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      natQ <= '0;
    end else if (strb.natSet) begin
      natQ[advReg] <= 1'b1;
    end else if (strb.natClr) begin
      natQ[advReg] <= 1'b0;
    end
  end

  assign natQryBit = natQ[natQryReg];
endmodule

// File: rtl/sltControl.sv
module sltControl
  import sltPkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                advValid,
  input  logic                advFault,
  input  logic                stValid,
  input  logic                chkValid,
  input  logic                chkPred,
  input  logic [ENTRIES-1:0]  advTagHit,
  input  logic [ENTRIES-1:0]  chkTagHit,
  input  logic [ENTRIES-1:0]  stOverlap,
  output ctrlStrobes_t        strb,
  output logic [ENTRIES-1:0]  wrSlot,
  output logic                chkDone,
  output logic                chkHit
);
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] olderQ [ENTRIES];  // olderQ[i][j]: slot i allocated before slot j

  logic advOk, advBad, chkFire;
  logic [ENTRIES-1:0] afterStore, sameReg, freeVec, sameSel, freeSel, oldestVec, validNext;

  assign advOk   = advValid && !advFault;
  assign advBad  = advValid && advFault;
  assign chkFire = chkValid && chkPred;

  // invalidation comes before allocation in the same cycle
  assign afterStore = validQ & ~(stValid ? stOverlap : '0);
  assign sameReg    = afterStore & advTagHit;
  assign freeVec    = ~afterStore;

  always_comb begin
    logic found;
    sameSel = '0;
    found   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sameReg[i] && !found) begin
        sameSel[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    freeSel = '0;
    found   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (freeVec[i] && !found) begin
        freeSel[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gOldest
    assign oldestVec[g] = &(olderQ[g] | (ENTRIES'(1) << g));
  end

  always_comb begin
    if (|sameSel)      wrSlot = sameSel;
    else if (|freeSel) wrSlot = freeSel;
    else               wrSlot = oldestVec;
  end

  always_comb begin
    validNext = afterStore;
    if (advBad) validNext = validNext & ~advTagHit;
    if (advOk)  validNext = validNext | wrSlot;
  end

  assign strb.write  = advOk;
  assign strb.natSet = advBad;
  assign strb.natClr = advOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          olderQ[i][j] <= (i < j);
        end
      end
    end else begin
      validQ <= validNext;
      if (advOk) begin
        for (int i = 0; i < ENTRIES; i++) begin
          for (int j = 0; j < ENTRIES; j++) begin
            if (wrSlot[i])      olderQ[i][j] <= 1'b0;
            else if (wrSlot[j]) olderQ[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkDone <= 1'b0;
      chkHit  <= 1'b0;
    end else begin
      chkDone <= chkFire;
      chkHit  <= chkFire && |(validQ & chkTagHit);
    end
  end
endmodule

// File: rtl/specLoadTracker.sv
module specLoadTracker
  import sltPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advValid,
  input  logic [REG_W-1:0]  advReg,
  input  logic [ADDR_W-1:0] advAddr,
  input  logic [1:0]        advSizeLog,
  input  logic              advFault,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSizeLog,
  input  logic              chkValid,
  input  logic              chkPred,
  input  logic [REG_W-1:0]  chkReg,
  output logic              chkDone,
  output logic              chkHit,
  input  logic [REG_W-1:0]  natQryReg,
  output logic              natQryBit
);
  ctrlStrobes_t       strb;
  logic [ENTRIES-1:0] wrSlot, advTagHit, chkTagHit, stOverlap;

  sltControl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .advValid(advValid), .advFault(advFault), .stValid(stValid),
    .chkValid(chkValid), .chkPred(chkPred),
    .advTagHit(advTagHit), .chkTagHit(chkTagHit), .stOverlap(stOverlap),
    .strb(strb), .wrSlot(wrSlot), .chkDone(chkDone), .chkHit(chkHit)
  );

  sltDatapath #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSlot(wrSlot),
    .advReg(advReg), .advAddr(advAddr), .advSizeLog(advSizeLog),
    .stAddr(stAddr), .stSizeLog(stSizeLog), .chkReg(chkReg),
    .natQryReg(natQryReg),
    .advTagHit(advTagHit), .chkTagHit(chkTagHit), .stOverlap(stOverlap),
    .natQryBit(natQryBit)
  );
endmodule

// File: rtl/sltChecker.sv
module sltChecker #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    advValid,
  input logic                    advFault,
  input logic [REG_W-1:0]        advReg,
  input logic                    stValid,
  input logic                    chkValid,
  input logic                    chkPred,
  input logic                    chkDone,
  input logic                    chkHit,
  input logic [ENTRIES-1:0]      validVec,
  input logic [ENTRIES-1:0]      chkTagHit,
  input logic [ENTRIES-1:0]      stOverlap,
  input logic [(1<<REG_W)-1:0]   natVec
);
  // R9
  done_needs_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkDone |-> $past(chkValid && chkPred));

  // R3
  hit_implies_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkHit |-> chkDone);

  // R7
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(validVec & chkTagHit));

  // R4
  store_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && !advValid) |=> ((validVec & $past(stOverlap)) == '0));

  // R10
  fault_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advValid && advFault) |=> natVec[$past(advReg)]);
endmodule

bind specLoadTracker sltChecker #(.ENTRIES(ENTRIES), .REG_W(REG_W)) uChk (
  .clk(clk), .rstN(rstN), .advValid(advValid), .advFault(advFault),
  .advReg(advReg), .stValid(stValid), .chkValid(chkValid), .chkPred(chkPred),
  .chkDone(chkDone), .chkHit(chkHit), .validVec(uCtrl.validQ),
  .chkTagHit(chkTagHit), .stOverlap(stOverlap), .natVec(uDp.natQ)
);

// File: tb/specLoadTracker_test.sv
module specLoadTracker_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        advValid, advFault, stValid, chkValid, chkPred;
  logic [6:0]  advReg, chkReg, natQryReg;
  logic [63:0] advAddr, stAddr;
  logic [1:0]  advSizeLog, stSizeLog;
  logic        chkDone, chkHit, natQryBit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  specLoadTracker uut (
    .clk(clk), .rstN(rstN), .advValid(advValid), .advReg(advReg),
    .advAddr(advAddr), .advSizeLog(advSizeLog), .advFault(advFault),
    .stValid(stValid), .stAddr(stAddr), .stSizeLog(stSizeLog),
    .chkValid(chkValid), .chkPred(chkPred), .chkReg(chkReg),
    .chkDone(chkDone), .chkHit(chkHit),
    .natQryReg(natQryReg), .natQryBit(natQryBit)
  );

  task automatic clearIn();
    advValid = 0; advFault = 0; advReg = '0; advAddr = '0; advSizeLog = '0;
    stValid = 0; stAddr = '0; stSizeLog = '0;
    chkValid = 0; chkPred = 0; chkReg = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  // one cycle of stimulus; on return, registered outputs reflect it
  task automatic cycle(input logic aV, input int aR, input longint aA, input int aS, input logic aF,
                       input logic sV, input longint sA, input int sS,
                       input logic cV, input logic cP, input int cR);
    @(negedge clk);
    advValid = aV; advReg = 7'(aR); advAddr = 64'(aA); advSizeLog = 2'(aS); advFault = aF;
    stValid = sV; stAddr = 64'(sA); stSizeLog = 2'(sS);
    chkValid = cV; chkPred = cP; chkReg = 7'(cR);
    @(negedge clk);
    clearIn();
  endtask

  task automatic adv(input int r, input longint a, input int s);
    cycle(1, r, a, s, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic store(input longint a, input int s);
    cycle(0, 0, 0, 0, 0, 1, a, s, 0, 0, 0);
  endtask

  task automatic expect1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check(input string tag, input int r, input logic expHit);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, r);
    expect1({tag, " done"}, chkDone, 1'b1);
    expect1({tag, " hit"}, chkHit, expHit);
  endtask

  function automatic longint slotAddr(input int r);
    return 64'h1000 + longint'(r) * 16;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearIn();
    natQryReg = 7'd0;
    rstN = 0;
    doReset();

    // R1: reset state
    expect1("R1 chkDone idle", chkDone, 1'b0);
    for (int r = 0; r < 128; r += 17) begin
      natQryReg = 7'(r);
      #1;
      expect1("R1 nat clear", natQryBit, 1'b0);
    end
    check("R1/R3 empty table", 0, 1'b0);

    // R2, R12: hit and repeated hit
    adv(5, 64'h80, 3);
    check("R2 hit", 5, 1'b1);
    check("R12 hit again", 5, 1'b1);
    check("R3 other reg", 6, 1'b0);

    // R4: overlap sweep, every size pair, offsets -8..+8
    for (int es = 0; es < 4; es++) begin
      for (int ss = 0; ss < 4; ss++) begin
        for (int off = -8; off <= 8; off++) begin
          longint e, s;
          logic ov;
          e = 64'h100;
          s = e + off;
          ov = (s < e + (longint'(1) << es)) && (e < s + (longint'(1) << ss));
          adv(5, e, es);
          store(s, ss);
          check($sformatf("R4 es=%0d ss=%0d off=%0d", es, ss, off), 5, !ov);
        end
      end
    end

    // R5: one store clears several entries, spares a neighbour
    adv(40, 64'h200, 2);
    adv(41, 64'h204, 2);
    adv(42, 64'h208, 2);
    adv(43, 64'h210, 2);
    store(64'h202, 3);
    check("R5 e40", 40, 1'b0);
    check("R5 e41", 41, 1'b0);
    check("R5 e42", 42, 1'b0);
    check("R5 e43 survives", 43, 1'b1);

    // R6: same-cycle store and advanced load
    cycle(1, 50, 64'h300, 3, 0, 1, 64'h300, 3, 0, 0, 0);
    check("R6 new entry survives", 50, 1'b1);

    // R7: replacement with a new address
    adv(51, 64'h400, 3);
    adv(51, 64'h500, 3);
    store(64'h400, 3);
    check("R7 old address ignored", 51, 1'b1);
    store(64'h500, 3);
    check("R7 new address clears", 51, 1'b0);

    // R9: predicate false
    adv(52, 64'h600, 3);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 52);
    expect1("R9 no response", chkDone, 1'b0);
    check("R9 state kept", 52, 1'b1);

    // R10: deferred fault
    natQryReg = 7'd53;
    cycle(1, 53, 64'h700, 3, 1, 0, 0, 0, 0, 0, 0);
    expect1("R10 nat set", natQryBit, 1'b1);
    check("R10 no entry", 53, 1'b0);
    adv(54, 64'h800, 3);
    cycle(1, 54, 64'h800, 3, 1, 0, 0, 0, 0, 0, 0);
    check("R10 entry removed", 54, 1'b0);
    adv(53, 64'h700, 3);
    expect1("R10 nat cleared", natQryBit, 1'b0);
    check("R10 clean reload", 53, 1'b1);

    // R11: check sees state before same-cycle updates
    adv(55, 64'h900, 3);
    cycle(0, 0, 0, 0, 0, 1, 64'h900, 3, 1, 1, 55);
    expect1("R11 pre-store hit", chkHit, 1'b1);
    check("R11 after store", 55, 1'b0);
    cycle(1, 56, 64'hA00, 3, 0, 0, 0, 0, 1, 1, 56);
    expect1("R11 pre-alloc miss", chkHit, 1'b0);
    check("R11 after alloc", 56, 1'b1);

    // R8: free slots first, then oldest eviction
    doReset();
    for (int r = 10; r <= 26; r++) adv(r, slotAddr(r), 3);
    check("R8 oldest evicted", 10, 1'b0);
    for (int r = 11; r <= 26; r++) check($sformatf("R8 kept %0d", r), r, 1'b1);
    store(slotAddr(15), 3);
    adv(31, slotAddr(31), 3);
    check("R8 free slot used", 11, 1'b1);
    check("R8 new in free", 31, 1'b1);
    adv(32, slotAddr(32), 3);
    check("R8 next oldest evicted", 11, 1'b0);
    check("R8 younger kept", 12, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule